// File: doc/BRIEF.md
# Binary Calendar Counter with Rollover Guard Window

This block keeps the time of day and the calendar date in plain binary fields and advances them once per second. The second is derived from a slow oscillator: the oscillator appears inside the system clock domain as a one-cycle strobe (`osc_tick`), and a divider counts `PRESCALE` enabled strobes per second. The calendar runs from year offset -128 to +127 around a base year (default 2112), which covers 1984 through 2239. Leap years follow the Gregorian rule. The day of the week is counted alongside the date.

Software sees six 16-bit registers on a simple bus. The bus has a write strobe, a 3-bit word address and a read path that follows the address combinationally. Around every second boundary there is a guard window that lasts two oscillator periods. During that window the four time registers read as 0xFFFF, writes to them are dropped, and the `unstable` output and status bit 0 are high. The carry through the calendar fields is done by a small state machine. It steps one field per system cycle and always finishes inside the guard window.

The carry machine has seven states. ST_IDLE waits, and it accepts register writes. On the divider's second pulse it goes to ST_SEC. From ST_SEC it goes to ST_MIN if seconds wrapped, and otherwise back to ST_IDLE. Each later state passes on the same way: ST_MIN to ST_HOUR when minutes wrap, ST_HOUR to ST_DAY when hours wrap, ST_DAY to ST_MONTH when the day of the month passes the month length, and ST_MONTH to ST_YEAR when December ends. Every state goes back to ST_IDLE when its field does not wrap, and ST_YEAR always does. Oscillator strobes must be at least 7 system cycles apart, and `PRESCALE` must be at least 4.

Top module: `cal_clock`

## Requirements
- R1: After reset the registers read as follows. Address 0 reads 0x0001, meaning offset 0, January. Address 1 reads 0x0001, meaning weekday 0, day 1. Addresses 2 and 3 read 0x0000, status (address 4) reads 0x0000, and configuration (address 5) reads 0x0000, so the oscillator is stopped.
- R2: The time advances only while configuration bit 3 (address 5) is 1. While it is 0 the divider and every field hold their values and `unstable` does not change. Configuration reads back only bit 3.
- R3: One second passes every `PRESCALE` enabled strobes. `unstable` rises on the strobe that takes the divider to its last count and falls two strobes later. The carry happens on the strobe between those two.
- R4: While `unstable` is high, reads of addresses 0 to 3 return 0xFFFF. Status and configuration reads are unaffected.
- R5: A write to addresses 0 to 3 is taken only on a clock edge before which `unstable` was low. A write on the edge that raises `unstable` still takes effect. A write one cycle later has no effect on any field.
- R6: The register fields are as follows. Address 0 holds the signed year offset in [15:8] and the month 1 to 12 in [3:0]. Address 1 holds the weekday 0 to 6 in [10:8] and the day of the month in [4:0]. Address 2 holds the hour in [12:8] and the minute in [5:0]. Address 3 holds the second in [5:0]. Every other bit ignores writes and reads 0.
- R7: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R8: At each midnight the weekday goes up by one, and 6 wraps to 0.
- R9: April, June, September and November end after day 30. The other months except February end after day 31. The day then returns to 1 and the month goes up by one.
- R10: February ends after day 29 when year = base + offset is a leap year (divisible by 4, and not by 100 unless also by 400). Otherwise it ends after day 28. So 1984, 2000 and 2112 are leap years, and 2100, 2113 and 2200 are not.
- R11: After 31 December the date becomes 1 January of offset + 1. Offset +127 wraps to -128.
- R12: The status register at address 4 holds the guard flag in bit 0, and its other bits read 0. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| unstable | output | 1 | Guard window around the second boundary |

## Verification
Two events can fall in the same cycle: a software write to a time register, and the oscillator strobe that opens the guard window. The bench generates the strobes itself on a fixed pattern. It counts cycles from the fall of `unstable`, places one write on the last edge before the window and another on the first edge inside it, and checks `unstable` at both points. It then judges both writes by the seconds value read after the next boundary: the first write must appear incremented, and the second must leave no trace.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_MONTH,
        ST_YEAR
    } carry_state_e;

    typedef struct packed {
        logic [7:0] year;
        logic [3:0] mon;
        logic [2:0] wday;
        logic [4:0] mday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    localparam logic [2:0] ADDR_YM   = 3'd0;
    localparam logic [2:0] ADDR_DAY  = 3'd1;
    localparam logic [2:0] ADDR_HM   = 3'd2;
    localparam logic [2:0] ADDR_SEC  = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;
    localparam logic [2:0] ADDR_CFG  = 3'd5;
    localparam int         CFG_RUN_BIT = 3;

    localparam logic [5:0] SEC_MAX  = 6'd59;
    localparam logic [5:0] MIN_MAX  = 6'd59;
    localparam logic [4:0] HOUR_MAX = 5'd23;
    localparam logic [2:0] WDAY_MAX = 3'd6;
    localparam logic [3:0] MON_MAX  = 4'd12;

    localparam cal_time_t RESET_TIME = '{
        year: 8'd0, mon: 4'd1, wday: 3'd0, mday: 5'd1,
        hour: 5'd0, min: 6'd0, sec: 6'd0
    };

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic run,
    output logic sec_pulse,
    output logic window
);
    localparam int CNT_W = $clog2(PRESCALE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt_q;

    // Restart one oscillator period past a boundary, outside the guard window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(1);
        end else if (osc_tick && run) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign sec_pulse = osc_tick && run && (cnt_q == LAST);
    assign window    = (cnt_q == LAST) || (cnt_q == '0);

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q)); // R2

    AST_PULSE_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> window); // R3

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
    parameter int BASE_YEAR = 2112
) (
    input  logic [7:0] year_off,
    input  logic [3:0] month,
    output logic [4:0] days,
    output logic       leap
);
    logic [11:0] full_year;

    assign full_year = 12'(BASE_YEAR) + {{4{year_off[7]}}, year_off};

    always_comb begin
        leap = ((full_year % 12'd4) == 12'd0) &&
               (((full_year % 12'd100) != 12'd0) || ((full_year % 12'd400) == 12'd0));
        unique case (month)
            4'd4, 4'd6, 4'd9, 4'd11: days = 5'd30;
            4'd2:                    days = leap ? 5'd29 : 5'd28;
            default:                 days = 5'd31;
        endcase
    end

endmodule

// File: rtl/cal_carry.sv
module cal_carry
    import cal_pkg::*;
#(
    parameter int BASE_YEAR = 2112
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_pulse,
    input  logic        window,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    output cal_time_t   now
);
    carry_state_e state_q, state_d;
    cal_time_t    now_q;
    logic [4:0]   mlen;
    logic         leap;

    cal_month_len #(.BASE_YEAR(BASE_YEAR)) u_mlen (
        .year_off (now_q.year),
        .month    (now_q.mon),
        .days     (mlen),
        .leap     (leap)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sec_pulse) state_d = ST_SEC;
            ST_SEC:   state_d = (now_q.sec  >= SEC_MAX)  ? ST_MIN   : ST_IDLE;
            ST_MIN:   state_d = (now_q.min  >= MIN_MAX)  ? ST_HOUR  : ST_IDLE;
            ST_HOUR:  state_d = (now_q.hour >= HOUR_MAX) ? ST_DAY   : ST_IDLE;
            ST_DAY:   state_d = (now_q.mday >= mlen)     ? ST_MONTH : ST_IDLE;
            ST_MONTH: state_d = (now_q.mon  >= MON_MAX)  ? ST_YEAR  : ST_IDLE;
            ST_YEAR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Field updates per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q <= RESET_TIME;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_en) begin
                        unique case (wr_addr)
                            2'd0: begin
                                now_q.year <= wr_data[15:8];
                                now_q.mon  <= wr_data[3:0];
                            end
                            2'd1: begin
                                now_q.wday <= wr_data[10:8];
                                now_q.mday <= wr_data[4:0];
                            end
                            2'd2: begin
                                now_q.hour <= wr_data[12:8];
                                now_q.min  <= wr_data[5:0];
                            end
                            2'd3: now_q.sec <= wr_data[5:0];
                        endcase
                    end
                end
                ST_SEC:  now_q.sec  <= (now_q.sec  >= SEC_MAX)  ? 6'd0 : now_q.sec + 6'd1;
                ST_MIN:  now_q.min  <= (now_q.min  >= MIN_MAX)  ? 6'd0 : now_q.min + 6'd1;
                ST_HOUR: now_q.hour <= (now_q.hour >= HOUR_MAX) ? 5'd0 : now_q.hour + 5'd1;
                ST_DAY: begin
                    now_q.wday <= (now_q.wday >= WDAY_MAX) ? 3'd0 : now_q.wday + 3'd1;
                    now_q.mday <= (now_q.mday >= mlen) ? 5'd1 : now_q.mday + 5'd1;
                end
                ST_MONTH: now_q.mon  <= (now_q.mon >= MON_MAX) ? 4'd1 : now_q.mon + 4'd1;
                ST_YEAR:  now_q.year <= now_q.year + 8'd1;
                default: ;
            endcase
        end
    end

    assign now = now_q;

    AST_CARRY_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> window); // R5

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEC && now_q.sec == SEC_MAX) |=> (now_q.sec == 6'd0)); // R7

    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DAY && now_q.wday == WDAY_MAX) |=> (now_q.wday == 3'd0)); // R8

    AST_MONTH_STARTS_DAY1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MONTH) |-> (now_q.mday == 5'd1)); // R9

    AST_LEAP_FEB29: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DAY && now_q.mon == 4'd2 && now_q.mday == 5'd28 && leap)
        |=> (now_q.mday == 5'd29)); // R10

    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_YEAR && now_q.year == 8'h7F) |=> (now_q.year == 8'h80)); // R11

endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter int PRESCALE  = 32768,
    parameter int BASE_YEAR = 2112
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        unstable
);
    logic      run_q;
    logic      sec_pulse;
    logic      window;
    logic      time_sel;
    logic      time_wr;
    cal_time_t now;

    cal_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .run       (run_q),
        .sec_pulse (sec_pulse),
        .window    (window)
    );

    assign time_sel = (bus_addr <= ADDR_SEC);
    assign time_wr  = bus_wr && time_sel && !window;

    cal_carry #(.BASE_YEAR(BASE_YEAR)) u_carry (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .window    (window),
        .wr_en     (time_wr),
        .wr_addr   (bus_addr[1:0]),
        .wr_data   (bus_wdata),
        .now       (now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              run_q <= 1'b0;
        else if (bus_wr && bus_addr == ADDR_CFG) run_q <= bus_wdata[CFG_RUN_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_YM:   bus_rdata = {now.year, 4'h0, now.mon};
            ADDR_DAY:  bus_rdata = {5'b0, now.wday, 3'b0, now.mday};
            ADDR_HM:   bus_rdata = {3'b0, now.hour, 2'b0, now.min};
            ADDR_SEC:  bus_rdata = {10'b0, now.sec};
            ADDR_STAT: bus_rdata = {15'b0, window};
            ADDR_CFG:  bus_rdata = {12'b0, run_q, 3'b0};
            default:   bus_rdata = '0;
        endcase
        if (window && time_sel) bus_rdata = 16'hFFFF;
    end

    assign unstable = window;

    AST_STOPPED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !sec_pulse); // R2

endmodule

// File: tb/cal_clock_bench.sv
`timescale 1ns/1ps
module cal_clock_bench;
    localparam int PRE = 4;
    localparam int OSC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        unstable;

    int checks = 0;
    int fails = 0;

    int m_yoff, m_mon, m_wday, m_mday, m_hour, m_min, m_sec;

    cal_clock #(.PRESCALE(PRE), .BASE_YEAR(2112)) u_cal_clock (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .unstable(unstable)
    );

    initial forever #2.5 clk = ~clk;

    initial begin
        forever begin
            repeat (OSC - 1) @(negedge clk);
            osc_tick = 1'b1;
            @(negedge clk);
            osc_tick = 1'b0;
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_fall();
        do @(negedge clk); while (!unstable);
        do @(negedge clk); while (unstable);
    endtask

    function automatic bit is_leap(int y);
        return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    endfunction

    function automatic int dim(int y, int m);
        case (m)
            4, 6, 9, 11: return 30;
            2:           return is_leap(y) ? 29 : 28;
            default:     return 31;
        endcase
    endfunction

    task automatic model_tick();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_wday = (m_wday == 6) ? 0 : m_wday + 1;
                    m_mday++;
                    if (m_mday > dim(2112 + m_yoff, m_mon)) begin
                        m_mday = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_yoff = (m_yoff == 127) ? -128 : m_yoff + 1;
                        end
                    end
                end
            end
        end
    endtask

    function automatic logic [15:0] pk_ym();
        return {8'(m_yoff), 8'(m_mon)};
    endfunction
    function automatic logic [15:0] pk_day();
        return {5'b0, 3'(m_wday), 3'b0, 5'(m_mday)};
    endfunction
    function automatic logic [15:0] pk_hm();
        return {3'b0, 5'(m_hour), 2'b0, 6'(m_min)};
    endfunction
    function automatic logic [15:0] pk_sec();
        return {10'b0, 6'(m_sec)};
    endfunction

    task automatic set_time(int y, int mo, int wd, int md, int h, int mi, int s);
        m_yoff = y; m_mon = mo; m_wday = wd; m_mday = md;
        m_hour = h; m_min = mi; m_sec = s;
        wait_fall();
        wr(3'd0, pk_ym());
        wr(3'd1, pk_day());
        wr(3'd2, pk_hm());
        wr(3'd3, pk_sec());
    endtask

    task automatic compare_all(input string req);
        logic [15:0] v;
        rd(3'd0, v); chk(req, v, pk_ym());
        rd(3'd1, v); chk(req, v, pk_day());
        rd(3'd2, v); chk(req, v, pk_hm());
        rd(3'd3, v); chk(req, v, pk_sec());
    endtask

    initial begin
        logic [15:0] v;
        int lo, hi;
        int years[7] = '{0, 1, -112, -12, 88, 127, -128};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(3'd0, v); chk("R1 ym", v, 16'h0001);
        rd(3'd1, v); chk("R1 day", v, 16'h0001);
        rd(3'd2, v); chk("R1 hm", v, 16'h0000);
        rd(3'd3, v); chk("R1 sec", v, 16'h0000);
        rd(3'd4, v); chk("R1 status", v, 16'h0000);
        rd(3'd5, v); chk("R1 cfg", v, 16'h0000);

        // R2: stopped oscillator holds everything
        repeat (100) @(negedge clk);
        rd(3'd3, v); chk("R2 frozen sec", v, 16'h0000);
        chk("R2 frozen flag", {15'b0, unstable}, 16'h0000);
        wr(3'd5, 16'hFFFF);
        rd(3'd5, v); chk("R2 cfg readback", v, 16'h0008);

        // R3: guard window length and spacing
        wait_fall();
        lo = 0;
        while (!unstable) begin lo++; @(negedge clk); end
        hi = 0;
        while (unstable) begin hi++; @(negedge clk); end
        chk("R3 open span", 16'(lo), 16'((PRE - 2) * OSC));
        chk("R3 guard span", 16'(hi), 16'(2 * OSC));

        // R6: field layout, reserved bits ignored
        m_yoff = -5; m_mon = 7; m_wday = 3; m_mday = 17;
        m_hour = 13; m_min = 45; m_sec = 20;
        wait_fall();
        wr(3'd0, 16'hFBF7);
        wr(3'd1, 16'hFBF1);
        wr(3'd2, 16'hEDED);
        wr(3'd3, 16'hFFD4);
        compare_all("R6");
        // R12: status write ignored
        wr(3'd4, 16'hFFFF);
        rd(3'd4, v); chk("R12 status write ignored", v, 16'h0000);

        // R5 / R4: write racing the window opening
        set_time(0, 3, 2, 10, 8, 30, 10);
        wait_fall();
        model_tick();
        compare_all("R5 pre");
        repeat (15) @(negedge clk);
        chk("R3 last open cycle", {15'b0, unstable}, 16'h0000);
        wr(3'd3, 16'd40);
        chk("R3 window opened", {15'b0, unstable}, 16'h0001);
        rd(3'd0, v); chk("R4 ym blocked", v, 16'hFFFF);
        rd(3'd1, v); chk("R4 day blocked", v, 16'hFFFF);
        rd(3'd2, v); chk("R4 hm blocked", v, 16'hFFFF);
        rd(3'd3, v); chk("R4 sec blocked", v, 16'hFFFF);
        rd(3'd4, v); chk("R12 status in window", v, 16'h0001);
        rd(3'd5, v); chk("R4 cfg readable", v, 16'h0008);
        wr(3'd3, 16'd50);
        wr(3'd0, 16'h2209);
        wait_fall();
        m_sec = 40;
        model_tick();
        compare_all("R5 edge write kept, late writes dropped");

        // R2: stop and restart
        wr(3'd5, 16'h0000);
        repeat (200) @(negedge clk);
        compare_all("R2 stopped");
        chk("R2 flag idle", {15'b0, unstable}, 16'h0000);
        wr(3'd5, 16'h0008);

        // R7: continuous run across minute, hour and day carries
        set_time(0, 1, 5, 31, 23, 58, 50);
        for (int i = 0; i < 80; i++) begin
            wait_fall();
            model_tick();
            compare_all("R7");
        end

        // R8-R11: month ends in several years
        foreach (years[k]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                int wd = (mo * 3) % 7;
                set_time(years[k], mo, wd, dim(2112 + years[k], mo), 23, 59, 59);
                wait_fall();
                model_tick();
                if (mo == 12)     compare_all("R11");
                else if (mo == 2) compare_all("R10");
                else              compare_all("R9");
                if (wd == 6) begin
                    rd(3'd1, v); chk("R8 weekday wrap", v, pk_day());
                end
            end
            set_time(years[k], 2, 6, 28, 23, 59, 59);
            wait_fall();
            model_tick();
            compare_all("R10 feb28");
            rd(3'd1, v); chk("R8 weekday 6 to 0", {8'b0, v[15:8]}, 16'h0000);
        end

        report();
    end

endmodule